// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the system clock. The bit rate is set by three configuration inputs. A 4-bit prescale value sets a factor of (value+1). A halving select, when clear, doubles the divide ratio. A wide-divide select multiplies the divide ratio by sixteen. The three factors multiply, so one small block covers system clock divided by 2 at the fast end down to system clock divided by 1024 at the slow end.

Next to the serial clock level, the block gives two one-cycle strobes for the shift engine. The leading strobe marks the move away from the idle level. The trailing strobe marks the return to it. The shift engine uses the clock-phase setting to pick which strobe samples and which one launches data, so clock phase is not an input here. The polarity input sets the idle level. While the enable is low, the clock rests at that level and all dividing counters are cleared. The configuration is expected to change only while the block is disabled.

Top module: `sck_prescaler`

## Requirements
- R1: With the block enabled, each serial clock half period lasts exactly H = F × (P+1) × D system clock cycles, where P is the 4-bit prescale input (0..15). A full serial clock period is therefore 2H cycles.
- R2: F is 1 when the halving select is 1, and F is 2 when the halving select is 0.
- R3: D is 16 when the wide-divide select is 1, and D is 1 when it is 0.
- R4: The slowest setting (wide-divide 1, prescale 15, halving select 0) gives a full period of 1024 system clocks.
- R5: One cycle after the enable is sampled low, the serial clock equals the polarity input and both strobes are 0. The counters are cleared, so the first toggle after enable comes H cycles after the first enabled edge.
- R6: The leading strobe is 1 for exactly one cycle: the cycle in which the serial clock first differs from the idle level. The trailing strobe is 1 for exactly one cycle: the cycle in which it returns to the idle level. The two strobes are never 1 together.
- R7: The polarity input sets the idle level. With polarity 1, the clock idles high and the leading edge is a falling edge.
- R8: During reset and in the first cycle after it, the serial clock equals the polarity input and both strobes are 0.
- R9: The fastest setting (prescale 0, halving select 1, wide-divide 0) toggles the serial clock on every system clock, so the leading and trailing strobes alternate cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the clock idle and clears the counters |
| prescale | input | 4 | Prescale value P, divide factor P+1 |
| div16_sel | input | 1 | 1 multiplies the ratio by 16 |
| fact_sel | input | 1 | 0 multiplies the ratio by 2 |
| cpol | input | 1 | Idle level of the serial clock |
| sck | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_stb | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
All three outputs are registers. Each one changes on the rising edge at which the enabled cycle count reaches H, and it is seen during the cycle that follows. The idle forcing likewise lands one edge after the enable is sampled low. The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares the model with the outputs at the next falling edge, so both sides look at the same cycle. It also measures the spacing between consecutive leading strobes against 2H for each configuration.

// File: rtl/sck_pkg.sv
package sck_pkg;
  // Number of system clocks in one serial clock half period.
  function automatic int calc_half(input int pm, input bit fact_on,
                                   input bit wide_on, input int wide_div);
    int f_mul;
    int d_mul;
    f_mul = fact_on ? 1 : 2;
    d_mul = wide_on ? wide_div : 1;
    return f_mul * (pm + 1) * d_mul;
  endfunction
endpackage

// File: rtl/sck_stage_ctr.sv
// One stage of the cascaded divider: counts tick_in pulses from 0 up to
// limit and passes a tick on when it wraps.
module sck_stage_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick_in,
  input  logic [W-1:0] limit,
  output logic         tick_out
);
  logic [W-1:0] cnt;
  logic         at_top;

  assign at_top   = (cnt == limit);
  assign tick_out = tick_in & at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (tick_in) cnt <= at_top ? '0 : cnt + 1'b1;
  end

  // Counter never runs past its terminal value (supports R1)
  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt <= limit));
  // A cleared stage restarts from zero (supports R5)
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
endmodule

// File: rtl/sck_edge_gen.sv
// Turns the half-period tick into the serial clock level and edge strobes.
module sck_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpol,
  input  logic half_tick,
  output logic sck,
  output logic lead_stb,
  output logic trail_stb
);
  logic at_idle;
  assign at_idle = (sck == cpol);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sck       <= cpol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= half_tick & at_idle;
      trail_stb <= half_tick & ~at_idle;
      if (half_tick) sck <= ~sck;
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));
  assert_lead_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sck != $past(sck)) && (sck != cpol));
  assert_trail_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |-> (sck != $past(sck)) && (sck == cpol));
  assert_idle_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sck == $past(cpol)) && !lead_stb && !trail_stb);
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int PM_W     = 4,
  parameter int WIDE_DIV = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PM_W-1:0] prescale,
  input  logic            div16_sel,
  input  logic            fact_sel,
  input  logic            cpol,
  output logic            sck,
  output logic            lead_stb,
  output logic            trail_stb
);
  import sck_pkg::*;

  localparam int WIDE_W = (WIDE_DIV > 1) ? $clog2(WIDE_DIV) : 1;
  localparam int GAP_W  = PM_W + WIDE_W + 3;

  logic clr;
  logic wide_tick;
  logic fact_tick;
  logic half_tick;

  assign clr = ~en;

  // Wide-divide stage: variant picked by the parameter
  generate
    if (WIDE_DIV > 1) begin : g_wide
      logic [WIDE_W-1:0] wide_lim;
      assign wide_lim = div16_sel ? WIDE_W'(WIDE_DIV - 1) : '0;
      sck_stage_ctr #(.W(WIDE_W)) u_wide (
        .clk(clk), .rst_n(rst_n), .clear(clr), .tick_in(en),
        .limit(wide_lim), .tick_out(wide_tick));
    end else begin : g_nowide
      assign wide_tick = en;
    end
  endgenerate

  // Factor stage: wraps after 2 ticks when the halving select is clear
  logic [0:0] fact_lim;
  assign fact_lim = fact_sel ? 1'b0 : 1'b1;
  sck_stage_ctr #(.W(1)) u_fact (
    .clk(clk), .rst_n(rst_n), .clear(clr), .tick_in(wide_tick),
    .limit(fact_lim), .tick_out(fact_tick));

  // Prescale stage: wraps after prescale+1 ticks
  sck_stage_ctr #(.W(PM_W)) u_pm (
    .clk(clk), .rst_n(rst_n), .clear(clr), .tick_in(fact_tick),
    .limit(prescale), .tick_out(half_tick));

  sck_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .half_tick(half_tick),
    .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb));

  // Checker: cycles between half-period ticks must equal the product
  logic [GAP_W-1:0] gap_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !en)  gap_cnt <= '0;
    else if (half_tick) gap_cnt <= '0;
    else                gap_cnt <= gap_cnt + 1'b1;
  end

  assert_half_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> (int'(gap_cnt) + 1 ==
                   calc_half(int'(prescale), fact_sel, div16_sel, WIDE_DIV)));
  assert_no_late_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (int'(gap_cnt) <
            calc_half(int'(prescale), fact_sel, div16_sel, WIDE_DIV)));
endmodule

// File: tb/sck_prescaler_bench.sv
`timescale 1ns/1ps
module sck_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] prescale = 4'd0;
  logic       div16_sel = 1'b0;
  logic       fact_sel = 1'b0;
  logic       cpol = 1'b0;
  logic       sck, lead_stb, trail_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sck_prescaler u_sck_prescaler (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale),
    .div16_sel(div16_sel), .fact_sel(fact_sel), .cpol(cpol),
    .sck(sck), .lead_stb(lead_stb), .trail_stb(trail_stb));

  function automatic int half_len(int p, bit f, bit d);
    int r;
    r = p + 1;
    if (!f) r = r * 2;
    if (d)  r = r * 16;
    return r;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_cnt = 0;
  bit m_sck = 1'b0, m_lead = 1'b0, m_trail = 1'b0;
  bit m_en_q = 1'b0;
  always @(posedge clk) begin
    m_lead = 1'b0;
    m_trail = 1'b0;
    if (!rst_n || !en) begin
      m_cnt = 0;
      m_sck = cpol;
    end else begin
      m_cnt++;
      if (m_cnt == half_len(prescale, fact_sel, div16_sel)) begin
        m_cnt = 0;
        if (m_sck == cpol) m_lead = 1'b1; else m_trail = 1'b1;
        m_sck = ~m_sck;
      end
    end
    m_en_q = rst_n && en;
  end

  // Compare every cycle, and measure the full period between leading strobes
  int cyc = 0;
  int last_lead = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(m_en_q ? cur_req : "R5", "sck", sck, m_sck);
      check("R6", "lead_stb", lead_stb, m_lead);
      check("R6", "trail_stb", trail_stb, m_trail);
      if (!m_en_q) last_lead = -1;
      else if (lead_stb) begin
        if (last_lead >= 0)
          check(cur_req, "period", cyc - last_lead,
                2 * half_len(prescale, fact_sel, div16_sel));
        last_lead = cyc;
      end
    end
  end

  task automatic run_cfg(int p, bit f, bit d, bit pol, string req);
    int n;
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    prescale = 4'(p); fact_sel = f; div16_sel = d; cpol = pol; cur_req = req;
    repeat (3) @(negedge clk);
    en = 1'b1;
    n = 6 * half_len(p, f, d) + 6;
    repeat (n) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "sck in reset", sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "sck after reset", sck, 0);
    check("R8", "lead after reset", lead_stb, 0);
    check("R8", "trail after reset", trail_stb, 0);

    run_cfg(5, 1'b1, 1'b0, 1'b0, "R1");
    run_cfg(2, 1'b1, 1'b0, 1'b0, "R1");
    run_cfg(5, 1'b0, 1'b0, 1'b0, "R2");
    run_cfg(3, 1'b1, 1'b1, 1'b0, "R3");
    run_cfg(1, 1'b0, 1'b0, 1'b1, "R7");
    run_cfg(0, 1'b1, 1'b0, 1'b0, "R9");
    run_cfg(15, 1'b0, 1'b1, 1'b0, "R4");
    check("R4", "slowest full period", 2 * half_len(15, 1'b0, 1'b1), 1024);

    // R5: disable mid half period, then restart from a cleared count
    prescale = 4'd9; fact_sel = 1'b1; div16_sel = 1'b0; cpol = 1'b1; cur_req = "R5";
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R5", "idle level after disable", sck, 1);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (9) @(negedge clk);
    check("R5", "no toggle before H", sck, 1);
    @(negedge clk);
    check("R5", "toggle at H", sck, 0);
    check("R5", "lead at H", lead_stb, 1);
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule